// File: doc/BRIEF.md
# USB Receive Serial Interface Engine

This block sits between a clock-and-data recovery stage and the protocol layer of a full-speed or low-speed USB device. For each recovered bit it gets a strobe, the line level (J or K) and a single-ended-zero flag. It looks for the start-of-packet pattern and converts the line transitions back into data bits. It removes the zeros that the transmitter inserted, packs the bits into bytes and checks the packet identifier.

The PID decides what happens to the rest of the packet. For a data packet, payload bytes are passed upward as they arrive. The two trailing CRC bytes are held back, and the CRC16 remainder is checked when the packet ends. For a token packet, the 11-bit field is split into device address and endpoint, or it is taken as a frame number for start-of-frame. Its CRC5 is checked before anything is announced. For a handshake, the only check is that no bytes follow the PID. Each packet ends with one `pkt_end` pulse, and `pkt_bad` qualifies that pulse.

Top module: `usb_rx_sie`

## Requirements
- R1: After reset, `rx_active`, `pid_vld`, `dat_vld`, `tok_vld`, `sof_stb`, `pkt_end` and `pkt_bad` are all low.
- R2: Line decoding: `rx_j`=1 means J (idle) and 0 means K. On a strobe, a bit is 1 when the line level equals the level at the previous strobe and 0 when it changed. After an SE0 bit the previous level is taken as J.
- R3: A packet starts only when a decoded 1 follows at least `SYNC_ZEROS` (default 6) consecutive decoded 0s while idle. A shorter run of zeros produces no `pid_vld`, no `pkt_end` and leaves `rx_active` low.
- R4: After six consecutive 1s (the final 1 of the start pattern counts), a following 0 is discarded and contributes nothing to byte assembly or CRC.
- R5: A 1 in the position where a stuffed 0 is due is an error. The packet ends with `pkt_bad`=1, and no further `dat_vld` occurs in that packet.
- R6: The first byte after the start pattern is the PID, assembled least significant bit first. When bits [7:4] equal the complement of bits [3:0], `pid_vld` pulses with `pid` = bits [3:0]. Otherwise there is no `pid_vld` and the packet ends bad.
- R7: When `pid[1:0]`=11 (data), each byte after the PID is presented on `dat_byte`/`dat_vld`, except the last two, which are the CRC. The packet is good when the CRC16 (poly 0x8005, preset all ones, over every bit after the PID) leaves residual 0x800D.
- R8: A data packet whose CRC16 residual is not 0x800D ends with `pkt_bad`=1.
- R9: When `pid[1:0]`=01 and the PID is not 0101, exactly two bytes must follow, forming an 11-bit field, LSB first, followed by a 5-bit CRC. CRC5 uses x^5+x^2+1, preset all ones, residual 01100. On a good packet `tok_vld` pulses together with `pkt_end`, with `tok_addr` = field[6:0] and `tok_ep` = field[10:7].
- R10: PID 0101 (start-of-frame) with a good CRC5 pulses `sof_stb` with `pkt_end` and gives the 11-bit field on `frame_num`. `tok_vld` does not pulse.
- R11: A token with a bad CRC5 ends with `pkt_bad`=1 and pulses neither `tok_vld` nor `sof_stb`.
- R12: A PID with bit 0 clear (handshake or special) is good only when no byte follows it. One extra byte makes the packet end bad.
- R13: End of packet is at least two SE0 bit times followed by a J bit. `pkt_end` pulses after that J bit and `rx_active` drops. A single SE0 bit before the J, or an end that is not on a byte boundary, gives `pkt_bad`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe marking a recovered bit |
| rx_j | input | 1 | Line level at the strobe: 1 = J, 0 = K |
| rx_se0 | input | 1 | Both lines low at the strobe |
| rx_active | output | 1 | High from start-pattern detection to end of packet |
| pid_vld | output | 1 | Pulse: valid PID received |
| pid | output | 4 | Received PID code |
| dat_vld | output | 1 | Pulse: payload byte on `dat_byte` |
| dat_byte | output | 8 | Payload byte |
| tok_vld | output | 1 | Pulse: good address/endpoint token |
| tok_addr | output | 7 | Token device address |
| tok_ep | output | 4 | Token endpoint number |
| sof_stb | output | 1 | Pulse: good start-of-frame token |
| frame_num | output | 11 | Frame number of the last good start-of-frame |
| pkt_end | output | 1 | Pulse: packet finished |
| pkt_bad | output | 1 | Qualifies `pkt_end`: packet in error |

## Verification
The in-line properties watch relations that must hold on every cycle. A token or frame announcement happens only on a clean packet end, and never both at once. Payload bytes appear only inside a data packet that is still active. `rx_active` is low once the end pulse fires, and a packet can only start on a non-SE0 strobe. Whether bytes are rebuilt correctly across stuffed zeros, which values the decoded fields carry, and whether CRC residuals, malformed PIDs, short start patterns, seven-one runs, extra handshake bytes and a single SE0 bit are judged correctly can only be shown by the bench's encoded packets.

// File: rtl/usb_rx_sie.sv
module usb_rx_sie #(
  parameter int SYNC_ZEROS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_stb,
  input  logic        rx_j,
  input  logic        rx_se0,
  output logic        rx_active,
  output logic        pid_vld,
  output logic [3:0]  pid,
  output logic        dat_vld,
  output logic [7:0]  dat_byte,
  output logic        tok_vld,
  output logic [6:0]  tok_addr,
  output logic [3:0]  tok_ep,
  output logic        sof_stb,
  output logic [10:0] frame_num,
  output logic        pkt_end,
  output logic        pkt_bad
);
  localparam logic [4:0]  CRC5_POLY  = 5'h05;
  localparam logic [4:0]  CRC5_RES   = 5'h0C;
  localparam logic [15:0] CRC16_POLY = 16'h8005;
  localparam logic [15:0] CRC16_RES  = 16'h800D;
  localparam logic [3:0]  PID_SOF    = 4'b0101;
  localparam logic [2:0]  STUFF_RUN  = 3'd6;

  logic        line_q;
  logic [2:0]  zrun, ones, bcnt;
  logic [1:0]  se0_cnt, nbytes;
  logic [7:0]  sr, h_old, h_new;
  logic        have_pid, err_q;
  logic [4:0]  crc5;
  logic [15:0] crc16;

  wire        nrz       = (rx_j == line_q);
  wire        seen_se0  = (se0_cnt != 2'd0);
  wire        act_bit   = bit_stb & rx_active & ~rx_se0 & ~seen_se0;
  wire        eop_now   = bit_stb & rx_active & ~rx_se0 & seen_se0;
  wire        at_stuff  = (ones == STUFF_RUN);
  wire        take      = act_bit & ~at_stuff;
  wire [7:0]  byte_in   = {nrz, sr[7:1]};
  wire        byte_done = take & (bcnt == 3'd7);
  wire        pid_ok    = (byte_in[7:4] == ~byte_in[3:0]);
  wire        is_tok    = (pid[1:0] == 2'b01);
  wire        is_dat    = (pid[1:0] == 2'b11);
  wire [4:0]  crc5_nx   = {crc5[3:0], 1'b0} ^ ((nrz ^ crc5[4]) ? CRC5_POLY : 5'h00);
  wire [15:0] crc16_nx  = {crc16[14:0], 1'b0} ^ ((nrz ^ crc16[15]) ? CRC16_POLY : 16'h0000);
  wire [10:0] tok_field = {h_new[2:0], h_old};
  wire        len_ok    = is_tok ? (nbytes == 2'd2) : (is_dat ? nbytes[1] : (nbytes == 2'd0));
  wire        crc_ok    = is_tok ? (crc5 == CRC5_RES) : (is_dat ? (crc16 == CRC16_RES) : 1'b1);
  wire        end_bad   = err_q | ~have_pid | (bcnt != 3'd0) | (se0_cnt < 2'd2) | ~rx_j | ~len_ok | ~crc_ok;
  wire        sync_hit  = bit_stb & ~rx_active & ~rx_se0 & nrz & (int'(zrun) >= SYNC_ZEROS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= 1'b1;
      zrun      <= '0;
      ones      <= '0;
      bcnt      <= '0;
      se0_cnt   <= '0;
      nbytes    <= '0;
      sr        <= '0;
      h_old     <= '0;
      h_new     <= '0;
      have_pid  <= 1'b0;
      err_q     <= 1'b0;
      crc5      <= '1;
      crc16     <= '1;
      rx_active <= 1'b0;
      pid_vld   <= 1'b0;
      pid       <= '0;
      dat_vld   <= 1'b0;
      dat_byte  <= '0;
      tok_vld   <= 1'b0;
      tok_addr  <= '0;
      tok_ep    <= '0;
      sof_stb   <= 1'b0;
      frame_num <= '0;
      pkt_end   <= 1'b0;
      pkt_bad   <= 1'b0;
    end else begin
      pid_vld <= 1'b0;
      dat_vld <= 1'b0;
      tok_vld <= 1'b0;
      sof_stb <= 1'b0;
      pkt_end <= 1'b0;
      pkt_bad <= 1'b0;

      if (bit_stb) line_q <= rx_se0 ? 1'b1 : rx_j;

      if (bit_stb && !rx_active) begin
        if (rx_se0 || nrz) zrun <= '0;
        else if (zrun != 3'd7) zrun <= zrun + 3'd1;
      end

      if (sync_hit) begin
        rx_active <= 1'b1;
        ones      <= 3'd1;
        bcnt      <= '0;
        se0_cnt   <= '0;
        nbytes    <= '0;
        have_pid  <= 1'b0;
        err_q     <= 1'b0;
        crc5      <= '1;
        crc16     <= '1;
      end

      if (bit_stb && rx_active && rx_se0 && se0_cnt != 2'd3)
        se0_cnt <= se0_cnt + 2'd1;

      if (act_bit) begin
        if (at_stuff) begin
          if (nrz) err_q <= 1'b1;
          else     ones  <= '0;
        end else begin
          ones <= nrz ? ones + 3'd1 : 3'd0;
          sr   <= byte_in;
          bcnt <= bcnt + 3'd1;
          if (have_pid) begin
            crc5  <= crc5_nx;
            crc16 <= crc16_nx;
          end
        end
      end

      if (byte_done) begin
        if (!have_pid) begin
          have_pid <= 1'b1;
          pid      <= byte_in[3:0];
          if (pid_ok) pid_vld <= 1'b1;
          else        err_q   <= 1'b1;
        end else begin
          h_old <= h_new;
          h_new <= byte_in;
          if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
          if (is_dat && nbytes[1] && !err_q) begin
            dat_vld  <= 1'b1;
            dat_byte <= h_old;
          end
        end
      end

      if (eop_now) begin
        rx_active <= 1'b0;
        se0_cnt   <= '0;
        pkt_end   <= 1'b1;
        pkt_bad   <= end_bad;
        if (!end_bad && is_tok) begin
          if (pid == PID_SOF) begin
            sof_stb   <= 1'b1;
            frame_num <= tok_field;
          end else begin
            tok_vld  <= 1'b1;
            tok_addr <= tok_field[6:0];
            tok_ep   <= tok_field[10:7];
          end
        end
      end
    end
  end

  // R13
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> !rx_active);

  // R9
  tok_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_vld || sof_stb) |-> (pkt_end && !pkt_bad));

  // R10
  tok_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tok_vld, sof_stb}));

  // R7
  dat_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_vld |-> (rx_active && pid[1:0] == 2'b11));

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(bit_stb && !rx_se0));

  // R6
  pid_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pid_vld |-> (rx_active && !dat_vld && !pkt_end));
endmodule

// File: tb/usb_rx_sie_bench.sv
module usb_rx_sie_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0, rx_j = 1'b1, rx_se0 = 1'b0;
  logic rx_active, pid_vld, dat_vld, tok_vld, sof_stb, pkt_end, pkt_bad;
  logic [3:0] pid, tok_ep;
  logic [7:0] dat_byte;
  logic [6:0] tok_addr;
  logic [10:0] frame_num;

  usb_rx_sie u_usb_rx_sie (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_j(rx_j), .rx_se0(rx_se0),
    .rx_active(rx_active), .pid_vld(pid_vld), .pid(pid), .dat_vld(dat_vld),
    .dat_byte(dat_byte), .tok_vld(tok_vld), .tok_addr(tok_addr), .tok_ep(tok_ep),
    .sof_stb(sof_stb), .frame_num(frame_num), .pkt_end(pkt_end), .pkt_bad(pkt_bad)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic lvl = 1'b1;
  int ones_run = 0;
  int n_b = 0, n_pid = 0, n_end = 0, n_tok = 0, n_sof = 0;
  logic [7:0] got_b [16];
  logic [3:0] got_pid;
  logic got_bad;
  logic [6:0] got_addr;
  logic [3:0] got_ep;
  logic [10:0] got_frame;
  logic [7:0] pay [8];

  always @(negedge clk) begin
    if (dat_vld) begin if (n_b < 16) got_b[n_b] = dat_byte; n_b++; end
    if (pid_vld) begin got_pid = pid; n_pid++; end
    if (pkt_end) begin got_bad = pkt_bad; n_end++; end
    if (tok_vld) begin got_addr = tok_addr; got_ep = tok_ep; n_tok++; end
    if (sof_stb) begin got_frame = frame_num; n_sof++; end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear();
    n_b = 0; n_pid = 0; n_end = 0; n_tok = 0; n_sof = 0; got_bad = 1'b0;
  endtask

  task automatic drive(input logic l, input logic s);
    @(negedge clk);
    rx_j = l; rx_se0 = s; bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic tx_raw(input logic b);
    if (!b) lvl = ~lvl;
    drive(lvl, 1'b0);
  endtask

  task automatic tx_bit(input logic b);
    tx_raw(b);
    if (b) begin
      ones_run++;
      if (ones_run == 6) begin tx_raw(1'b0); ones_run = 0; end
    end else ones_run = 0;
  endtask

  task automatic tx_sync(input int nz);
    repeat (nz) tx_raw(1'b0);
    tx_raw(1'b1);
    ones_run = 1;
  endtask

  task automatic tx_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) tx_bit(b[i]);
  endtask

  task automatic tx_eop(input int n_se0);
    repeat (n_se0) drive(1'b0, 1'b1);
    lvl = 1'b1;
    repeat (3) drive(1'b1, 1'b0);
  endtask

  function automatic logic [15:0] c16_step(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((b ^ c[15]) ? 16'h8005 : 16'h0000);
  endfunction

  function automatic logic [4:0] c5_step(input logic [4:0] c, input logic b);
    return {c[3:0], 1'b0} ^ ((b ^ c[4]) ? 5'h05 : 5'h00);
  endfunction

  task automatic send_data(input logic [3:0] p, input int n, input bit bad_crc, input int n_se0);
    logic [15:0] c = 16'hFFFF;
    tx_sync(7);
    tx_byte({~p, p});
    for (int k = 0; k < n; k++) begin
      tx_byte(pay[k]);
      for (int i = 0; i < 8; i++) c = c16_step(c, pay[k][i]);
    end
    for (int i = 15; i >= 0; i--) tx_bit(~c[i] ^ (bad_crc && i == 0));
    tx_eop(n_se0);
  endtask

  task automatic send_token(input logic [3:0] p, input logic [10:0] f, input bit bad_crc);
    logic [4:0] c = 5'h1F;
    tx_sync(7);
    tx_byte({~p, p});
    for (int i = 0; i < 11; i++) begin tx_bit(f[i]); c = c5_step(c, f[i]); end
    for (int i = 4; i >= 0; i--) tx_bit(~c[i] ^ (bad_crc && i == 2));
    tx_eop(2);
  endtask

  task automatic t_reset();
    chk("R1", "rx_active", rx_active, 0);
    chk("R1", "pkt_end", pkt_end, 0);
    chk("R1", "pid_vld|dat_vld|tok_vld|sof_stb|pkt_bad",
        {pid_vld, dat_vld, tok_vld, sof_stb, pkt_bad}, 0);
  endtask

  task automatic t_data_stuffed();
    clear();
    pay[0] = 8'hFF; pay[1] = 8'h00; pay[2] = 8'h7E;
    send_data(4'b0011, 3, 1'b0, 2);
    chk("R6", "pid", got_pid, 4'b0011);
    chk("R7", "byte count", n_b, 3);
    chk("R4", "byte0 after stuffing", got_b[0], 8'hFF);
    chk("R2", "byte1", got_b[1], 8'h00);
    chk("R7", "byte2", got_b[2], 8'h7E);
    chk("R13", "end count", n_end, 1);
    chk("R7", "bad flag", got_bad, 0);
    chk("R13", "rx_active after end", rx_active, 0);
  endtask

  task automatic t_data_empty();
    clear();
    send_data(4'b1011, 0, 1'b0, 2);
    chk("R7", "empty bytes", n_b, 0);
    chk("R7", "empty bad", got_bad, 0);
    chk("R6", "empty pid", got_pid, 4'b1011);
  endtask

  task automatic t_data_badcrc();
    clear();
    pay[0] = 8'h12; pay[1] = 8'h34;
    send_data(4'b0011, 2, 1'b1, 2);
    chk("R8", "end count", n_end, 1);
    chk("R8", "bad flag", got_bad, 1);
  endtask

  task automatic t_token();
    clear();
    send_token(4'b0001, {4'd5, 7'h3A}, 1'b0);
    chk("R9", "tok count", n_tok, 1);
    chk("R9", "addr", got_addr, 7'h3A);
    chk("R9", "ep", got_ep, 4'd5);
    chk("R9", "bad flag", got_bad, 0);
    chk("R10", "no sof on token", n_sof, 0);
  endtask

  task automatic t_sof();
    clear();
    send_token(4'b0101, 11'h5A3, 1'b0);
    chk("R10", "sof count", n_sof, 1);
    chk("R10", "frame", got_frame, 11'h5A3);
    chk("R10", "no tok on sof", n_tok, 0);
  endtask

  task automatic t_token_badcrc();
    clear();
    send_token(4'b1001, 11'h0F1, 1'b1);
    chk("R11", "tok count", n_tok, 0);
    chk("R11", "end count", n_end, 1);
    chk("R11", "bad flag", got_bad, 1);
  endtask

  task automatic t_handshake();
    clear();
    tx_sync(7); tx_byte(8'hD2); tx_eop(2);
    chk("R12", "ack bad flag", got_bad, 0);
    chk("R12", "ack pid", got_pid, 4'b0010);
    clear();
    tx_sync(7); tx_byte(8'hD2); tx_byte(8'h55); tx_eop(2);
    chk("R12", "ack+byte bad flag", got_bad, 1);
  endtask

  task automatic t_bad_pid();
    clear();
    tx_sync(7); tx_byte(8'h13); tx_eop(2);
    chk("R6", "pid_vld count", n_pid, 0);
    chk("R6", "bad flag", got_bad, 1);
  endtask

  task automatic t_stuff_err();
    clear();
    tx_sync(7); tx_byte(8'hC3);
    repeat (7) tx_raw(1'b1);
    tx_byte(8'h00); tx_byte(8'h00); tx_byte(8'h00);
    tx_eop(2);
    chk("R5", "data bytes", n_b, 0);
    chk("R5", "end count", n_end, 1);
    chk("R5", "bad flag", got_bad, 1);
  endtask

  task automatic t_short_sync();
    clear();
    tx_sync(4);
    tx_raw(1'b0); tx_raw(1'b1); tx_raw(1'b0); tx_raw(1'b1);
    tx_eop(2);
    chk("R3", "pid_vld count", n_pid, 0);
    chk("R3", "end count", n_end, 0);
    chk("R3", "rx_active", rx_active, 0);
  endtask

  task automatic t_single_se0();
    clear();
    pay[0] = 8'hA5;
    send_data(4'b0011, 1, 1'b0, 1);
    chk("R13", "end count", n_end, 1);
    chk("R13", "bad flag", got_bad, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) drive(1'b1, 1'b0);
    t_data_stuffed();
    t_data_empty();
    t_data_badcrc();
    t_token();
    t_sof();
    t_token_badcrc();
    t_handshake();
    t_bad_pid();
    t_stuff_err();
    t_short_sync();
    t_single_se0();
    t_data_stuffed();
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    report();
    $finish;
  end
endmodule